// File: doc/BRIEF.md
# Synchronizable Power-of-Two Decimator

This block takes multi-bit samples from an oversampling modulator, one per master clock when the input valid is high, and reduces their rate by 2^n using a third-order cascaded integrator-comb filter. The block also generates the output data-ready strobe by dividing the accepted sample stream by the same ratio. The converter is therefore the side that drives the strobe, and a downstream host only has to capture words on the strobe.

A rising edge on `sync_in` restarts the filter, the rate divider and the settling count together. Tying `sync_in` to several channels that share a master clock lines their output frames up. The ratio exponent `n_cfg` is latched only at that restart, so a frame never changes length part way through. After a restart the strobe keeps running, but the first three words are withheld while the filter history fills with fresh samples.

The stream interface has no back-pressure. The input is valid-only and the block accepts every sample presented with `in_valid` high. The output is a one-cycle valid pulse, and the host must take `out_data` in that cycle.

Top module: `cicdec`

## Requirements
- R1: While and directly after reset, `drdy`, `out_valid` and `out_data` are all zero, and the active exponent is N_MAX.
- R2: `drdy` pulses for one cycle after every 2^n accepted samples, where n is the active exponent. It is high in the cycle that follows the clock edge that accepted the 2^n-th sample.
- R3: A valid word equals the sum over k = 0 .. 3(2^n − 1) of h[k]·x[j−k]. Here x[j] is the newest accepted sample, samples before the last restart count as zero, and h is the 2^n-long boxcar convolved with itself three times. The input is signed two's complement, and the result is sign-extended to OUT_W bits.
- R4: When `sync_in` is first seen high at clock edge c, the clock edge c+1 clears the filter state, the divider and the settling count, latches `n_cfg`, and discards any sample offered there. Counting restarts with the sample at edge c+2. Holding `sync_in` high produces only one restart.
- R5: The first three `drdy` pulses after a restart or reset carry `out_valid` low. From the fourth pulse onward, `out_valid` equals `drdy`.
- R6: A restart during settling starts the three-word settling count again from zero.
- R7: A change of `n_cfg` without a restart has no effect on the output rate or on the data.
- R8: A value of `n_cfg` greater than N_MAX is used as N_MAX.
- R9: `out_valid` is never high without `drdy`, and `out_data` keeps its value in every cycle where `out_valid` is low.
- R10: Cycles with `in_valid` low neither advance the divider nor change the filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | IN_W | Signed modulator sample |
| n_cfg | input | NW | Requested ratio exponent, latched on restart |
| sync_in | input | 1 | Restart request, acts on its rising edge |
| drdy | output | 1 | Output-rate strobe, one cycle per frame |
| out_valid | output | 1 | Word on out_data is settled and valid |
| out_data | output | OUT_W | Decimated signed word |

## Verification
The checks assume that `sync_in` and `in_valid` are both zero during reset, because the edge detector and the sample-presence property look back across the reset boundary. They also assume that `in_sample` fits the declared signed width. The stimulus holds every input low through reset, drives only values within range, and changes inputs on the falling clock edge. Sync pulses are at least one cycle wide and are followed by a low cycle before the next request, so each intended restart is seen as a separate rising edge.

// File: rtl/cicdec_pkg.sv
package cicdec_pkg;
  // Filter order and number of output words withheld after a restart.
  localparam int CIC_ORDER    = 3;
  localparam int SETTLE_WORDS = 3;
endpackage

// File: rtl/cicdec_rate_ctl.sv
module cicdec_rate_ctl
  import cicdec_pkg::*;
#(
  parameter int N_MAX = 6,
  parameter int NW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_in,
  input  logic [NW-1:0] n_cfg,
  input  logic          in_valid,
  output logic          sync_edge,
  output logic [NW-1:0] n_act,
  output logic          tick,
  output logic          settled
);
  localparam int CW = N_MAX;
  localparam int SW = $clog2(SETTLE_WORDS + 1);

  logic          sync_r, sync_d;
  logic [CW-1:0] cnt;
  logic [CW-1:0] term;
  logic [SW-1:0] settle;
  logic [NW-1:0] n_lim;

  // Two flops: first takes the asynchronous request, second gives the edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_r <= sync_in;
      sync_d <= sync_r;
    end
  end
  assign sync_edge = sync_r & ~sync_d;

  assign n_lim = (n_cfg > NW'(N_MAX)) ? NW'(N_MAX) : n_cfg;

  // Terminal count is 2^n - 1: the low n bits set.
  always_comb begin
    for (int i = 0; i < CW; i++) term[i] = (i < int'(n_act));
  end

  assign tick    = in_valid & ~sync_edge & (cnt == term);
  assign settled = (settle == SW'(SETTLE_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      n_act  <= NW'(N_MAX);
      cnt    <= '0;
      settle <= '0;
    end else if (sync_edge) begin
      n_act  <= n_lim;
      cnt    <= '0;
      settle <= '0;
    end else if (in_valid) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && !settled) settle <= settle + 1'b1;
    end
  end
endmodule

// File: rtl/cicdec_integ.sv
module cicdec_integ
  import cicdec_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [AW-1:0] x,
  output logic signed [AW-1:0] sum_now
);
  // stage_in[0] is the sample; stage_in[g+1] is the updated sum of stage g.
  logic signed [AW-1:0] acc_q    [CIC_ORDER];
  logic signed [AW-1:0] stage_in [CIC_ORDER+1];

  assign stage_in[0] = x;

  for (genvar g = 0; g < CIC_ORDER; g++) begin : g_stage
    assign stage_in[g+1] = acc_q[g] + stage_in[g];
    always_ff @(posedge clk) begin
      if (rst || clr)  acc_q[g] <= '0;
      else if (en)     acc_q[g] <= stage_in[g+1];
    end
  end

  assign sum_now = stage_in[CIC_ORDER];
endmodule

// File: rtl/cicdec_comb.sv
module cicdec_comb
  import cicdec_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [AW-1:0] v,
  output logic signed [AW-1:0] y
);
  logic signed [AW-1:0] prev_q [CIC_ORDER];
  logic signed [AW-1:0] diff   [CIC_ORDER+1];

  assign diff[0] = v;

  for (genvar g = 0; g < CIC_ORDER; g++) begin : g_stage
    assign diff[g+1] = diff[g] - prev_q[g];
    always_ff @(posedge clk) begin
      if (rst || clr)  prev_q[g] <= '0;
      else if (en)     prev_q[g] <= diff[g];
    end
  end

  assign y = diff[CIC_ORDER];
endmodule

// File: rtl/cicdec.sv
module cicdec
  import cicdec_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int N_MAX = 6,
  parameter int NW    = 3,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  input  logic [NW-1:0]    n_cfg,
  input  logic             sync_in,
  output logic             drdy,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int AW = IN_W + CIC_ORDER * N_MAX;

  logic                 sync_edge;
  logic [NW-1:0]        n_act;
  logic                 tick;
  logic                 settled;
  logic signed [AW-1:0] x_ext;
  logic signed [AW-1:0] integ_sum;
  logic signed [AW-1:0] comb_y;
  logic [OUT_W-1:0]     word;

  cicdec_rate_ctl #(.N_MAX(N_MAX), .NW(NW)) u_rate (
    .clk(clk), .rst(rst), .sync_in(sync_in), .n_cfg(n_cfg),
    .in_valid(in_valid), .sync_edge(sync_edge), .n_act(n_act),
    .tick(tick), .settled(settled)
  );

  assign x_ext = {{(AW-IN_W){in_sample[IN_W-1]}}, in_sample};

  cicdec_integ #(.AW(AW)) u_integ (
    .clk(clk), .rst(rst), .clr(sync_edge), .en(in_valid & ~sync_edge),
    .x(x_ext), .sum_now(integ_sum)
  );

  cicdec_comb #(.AW(AW)) u_comb (
    .clk(clk), .rst(rst), .clr(sync_edge), .en(tick),
    .v(integ_sum), .y(comb_y)
  );

  // Word width: widen by sign extension, or keep the top bits.
  if (OUT_W >= AW) begin : g_extend
    assign word = {{(OUT_W-AW){comb_y[AW-1]}}, comb_y};
  end else begin : g_trunc
    assign word = comb_y[AW-1 -: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      drdy      <= tick;
      out_valid <= tick & settled;
      if (tick && settled) out_data <= word;
    end
  end
endmodule

// File: rtl/cicdec_checks.sv
module cicdec_checks #(
  parameter int N_MAX = 6,
  parameter int NW    = 3,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             sync_edge,
  input logic [NW-1:0]    n_act,
  input logic             drdy,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  a_r9_valid_needs_drdy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> drdy);

  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  a_r4_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    sync_edge |=> (!drdy && !out_valid));

  a_r7_n_only_on_sync: assert property (@(posedge clk) disable iff (rst)
    !sync_edge |=> $stable(n_act));

  a_r8_n_bounded: assert property (@(posedge clk) disable iff (rst)
    n_act <= NW'(N_MAX));

  a_r10_strobe_needs_sample: assert property (@(posedge clk) disable iff (rst)
    drdy |-> $past(in_valid));
endmodule

bind cicdec cicdec_checks #(.N_MAX(N_MAX), .NW(NW), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sync_edge(sync_edge),
  .n_act(n_act), .drdy(drdy), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cicdec_tb_top.sv
module cicdec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 4;
  localparam int N_MAX = 6;
  localparam int NW    = 3;
  localparam int OUT_W = 24;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [IN_W-1:0]  in_sample;
  logic [NW-1:0]    n_cfg;
  logic             sync_in;
  logic             drdy;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  string phase = "R1";

  cicdec #(.IN_W(IN_W), .N_MAX(N_MAX), .NW(NW), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .n_cfg(n_cfg), .sync_in(sync_in), .drdy(drdy), .out_valid(out_valid),
    .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int     hist [256];
  int     h    [256];
  int     nsamp, m_cnt, m_settle, m_n;
  bit     prev_sync, clr_pend;
  bit     e_drdy, e_valid;
  longint e_hold;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s): actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  function automatic void calc_h(int r);
    for (int k = 0; k < 256; k++) h[k] = 0;
    for (int a = 0; a < r; a++)
      for (int b = 0; b < r; b++)
        for (int c = 0; c < r; c++) h[a+b+c]++;
  endfunction

  function automatic longint fir(int r);
    longint acc = 0;
    for (int k = 0; k <= 3*(r-1); k++) begin
      int idx = nsamp - 1 - k;
      if (idx >= 0) acc += longint'(h[k]) * longint'(hist[idx % 256]);
    end
    return acc;
  endfunction

  function automatic void model_reset();
    nsamp = 0; m_cnt = 0; m_settle = 0; m_n = N_MAX;
    prev_sync = 0; clr_pend = 0; e_drdy = 0; e_valid = 0; e_hold = 0;
    calc_h(1 << N_MAX);
  endfunction

  function automatic void model_edge(int x, bit v, bit s, int cfg);
    e_drdy = 0; e_valid = 0;
    if (clr_pend) begin                       // R4 restart edge
      m_cnt = 0; m_settle = 0; nsamp = 0;
      m_n = (cfg > N_MAX) ? N_MAX : cfg;      // R8 clamp
      calc_h(1 << m_n);
    end else if (v) begin
      hist[nsamp % 256] = x;
      nsamp++;
      m_cnt++;
      if (m_cnt == (1 << m_n)) begin
        m_cnt  = 0;
        e_drdy = 1;
        if (m_settle == 3) begin
          e_valid = 1;
          e_hold  = fir(1 << m_n);
        end else m_settle++;
      end
    end
    clr_pend  = s && !prev_sync;
    prev_sync = s;
  endfunction

  // One master-clock cycle: drive at the falling edge, check at the next one.
  task automatic step(int x, bit v, bit s, int cfg);
    longint act;
    in_sample = IN_W'(x);
    in_valid  = v;
    sync_in   = s;
    n_cfg     = NW'(cfg);
    @(posedge clk);
    model_edge(x, v, s, cfg);
    @(negedge clk);
    check(drdy == e_drdy, "R2", longint'(drdy), longint'(e_drdy));
    check(out_valid == e_valid, "R5", longint'(out_valid), longint'(e_valid));
    act = longint'($signed(out_data));
    if (e_valid) check(act == e_hold, "R3", act, e_hold);
    else         check(act == e_hold, "R9", act, e_hold);
  endtask

  function automatic int rnd_x();
    return int'($urandom_range(15)) - 8;
  endfunction

  task automatic run(int cycles, int cfg, int valid_pct);
    for (int i = 0; i < cycles; i++)
      step(rnd_x(), ($urandom_range(99) < valid_pct), 1'b0, cfg);
  endtask

  task automatic do_sync(int cfg);
    step(rnd_x(), 1'b1, 1'b1, cfg);
    step(rnd_x(), 1'b1, 1'b0, cfg);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_sample = '0; sync_in = 1'b0; n_cfg = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    phase = "R1";
    check(drdy == 1'b0, "R1", longint'(drdy), 0);
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    check(out_data == '0, "R1", longint'(out_data), 0);
    rst = 1'b0;

    // R7: no restart, so the reset exponent stays while n_cfg says 2.
    phase = "R7";
    run(300, 2, 100);

    // R4: restart to n=2 with a continuous stream.
    phase = "R4";
    do_sync(2);
    run(200, 2, 100);

    // R4: sync held high for several cycles gives one restart only.
    phase = "R4";
    for (int i = 0; i < 6; i++) step(rnd_x(), 1'b1, 1'b1, 1);
    run(120, 5, 100);

    // R10: gaps in the input stream.
    phase = "R10";
    do_sync(3);
    run(400, 3, 60);

    // R6: restart in the middle of settling.
    phase = "R6";
    do_sync(3);
    run(14, 3, 100);
    do_sync(3);
    run(80, 3, 100);

    // R2: ratio 1, strobe every accepted sample.
    phase = "R2";
    do_sync(0);
    run(40, 0, 80);

    // R8: out-of-range exponent clamps to N_MAX.
    phase = "R8";
    do_sync(7);
    run(400, 7, 100);

    // R3: full-scale negative and positive inputs.
    phase = "R3";
    do_sync(4);
    for (int i = 0; i < 120; i++) step(-8, 1'b1, 1'b0, 4);
    do_sync(4);
    for (int i = 0; i < 120; i++) step(7, 1'b1, 1'b0, 4);

    // Random mixes of exponent and valid density.
    phase = "R3";
    for (int t = 0; t < 6; t++) begin
      int nn = int'($urandom_range(5));
      do_sync(nn);
      run(5 * (1 << nn) + 40, nn, 70 + int'($urandom_range(30)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule